// File: doc/BRIEF.md
# Full/Half Step Motor Phase Sequencer

This block produces the coil phase pattern for a four-phase stepper motor. It keeps a position within a repeating sequence of coil energisation patterns. On every step strobe it moves that position one entry forward or one entry back, and it wraps around at either end of the sequence. The pattern is driven out of a register, with the coil nibble repeated in both halves of the byte, so the output can feed a port or a driver stage directly and cannot glitch between steps.

Two sequences are available, chosen by a mode input. The full-step sequence always energises two adjacent coils. The half-step sequence alternates between one coil and two adjacent coils. Every full-step pattern also appears in the half-step sequence, at the odd positions. The block therefore tracks a single position in half-step units. In full-step mode it moves two units per step and keeps the position on an odd unit. When the mode drops from half-step to full-step while the position sits on a single-coil entry, the position moves to the next entry in forward order, so the output is always a pattern of the active sequence.

Step timing, acceleration, current control and the power stage are handled outside the block.

Top module: `stepper_phase_seq`

## Requirements
- R1: While rst_n is low the output is 8'h11, which is position 0 of the half-step sequence. Within four clock cycles after rst_n rises with half_i low, the output becomes 8'h33, the first full-step entry.
- R2: With half_i low and dir_i high (forward), each clock cycle with step_i high moves the output to the next entry of the cycle 8'h33, 8'h66, 8'hCC, 8'h99, and 8'h99 is followed by 8'h33. The new value is visible after that clock edge.
- R3: With half_i low and dir_i low (reverse), each step moves the output through the full-step cycle in the opposite order: 8'h33, 8'h99, 8'hCC, 8'h66, and then back to 8'h33.
- R4: With half_i high and dir_i high, each step moves the output to the next entry of the cycle 8'h11, 8'h33, 8'h22, 8'h66, 8'h44, 8'hCC, 8'h88, 8'h99, and 8'h99 is followed by 8'h11.
- R5: With half_i high and dir_i low, each step moves the output one entry back in the half-step cycle, and 8'h11 is followed by 8'h99.
- R6: When half_i is low and the output is a single-coil half-step entry (8'h11, 8'h22, 8'h44 or 8'h88), the output becomes the entry that follows it in forward half-step order one clock edge later, with no step needed. For example, 8'h88 becomes 8'h99 and 8'h11 becomes 8'h33.
- R7: Raising half_i while on a full-step entry leaves the output unchanged. The next half-step then continues from that entry.
- R8: A cycle without step_i leaves the output unchanged, except for the adjustment in R6. A cycle with step_i always changes the output.
- R9: The upper and lower nibbles of the output are always equal. One clock edge after a cycle with half_i low, the output has exactly two coil bits set in each nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| step_i | input | 1 | Step strobe; each cycle it is high counts as one step |
| dir_i | input | 1 | Direction: 1 = forward (increasing position), 0 = reverse |
| half_i | input | 1 | Mode: 1 = half-step sequence, 0 = full-step sequence |
| phase_o | output | 8 | Registered coil pattern, with the coil nibble repeated in both halves |

## Verification
A wrong position value shows on phase_o at the clock edge that follows the next step. It appears either as a pattern out of sequence order or, in full-step mode, as a single-coil pattern. A missed snap on a mode change shows one edge after half_i falls, and a wrong wrap shows on the step that crosses the end of the table. Because every step must change the output, a stuck position register is visible on the first step it swallows.

// File: rtl/stepper_pkg.sv
package stepper_pkg;

  typedef enum logic {
    DIR_REV = 1'b0,
    DIR_FWD = 1'b1
  } step_dir_e;

  typedef enum logic {
    MODE_FULL = 1'b0,
    MODE_HALF = 1'b1
  } step_mode_e;

endpackage

// File: rtl/stepper_phase_lut.sv
module stepper_phase_lut #(
  parameter int NUM_PHASES = 4,
  localparam int LEN   = 2 * NUM_PHASES,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic [IDX_W-1:0]        idx_i,
  output logic [2*NUM_PHASES-1:0] pattern_o
);

  logic [NUM_PHASES-1:0] coil [LEN];

  // Even positions energise one coil, odd positions energise that coil and the next.
  for (genvar i = 0; i < LEN; i++) begin : g_ent
    localparam int A = i / 2;
    localparam int B = (i / 2 + 1) % NUM_PHASES;
    if (i % 2 == 1) begin : g_pair
      assign coil[i] = (NUM_PHASES'(1) << A) | (NUM_PHASES'(1) << B);
    end else begin : g_single
      assign coil[i] = NUM_PHASES'(1) << A;
    end
  end

  assign pattern_o = {2{coil[idx_i]}};

endmodule

// File: rtl/stepper_pos_next.sv
module stepper_pos_next
  import stepper_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  localparam int LEN   = 2 * NUM_PHASES,
  localparam int IDX_W = $clog2(LEN)
) (
  input  logic [IDX_W-1:0] pos_i,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             half_i,
  output logic [IDX_W-1:0] pos_nxt_o
);

  localparam logic [IDX_W:0] LEN_W = (IDX_W+1)'(LEN);

  logic [IDX_W:0] base;
  logic [IDX_W:0] inc;
  logic [IDX_W:0] fwd_sum;
  logic [IDX_W:0] fwd_pos;
  logic [IDX_W:0] rev_pos;

  always_comb begin
    // Full-step positions live on odd half-step units.
    if (half_i == MODE_HALF) begin
      base = {1'b0, pos_i};
      inc  = (IDX_W+1)'(1);
    end else begin
      base = {1'b0, pos_i} | (IDX_W+1)'(1);
      inc  = (IDX_W+1)'(2);
    end

    fwd_sum = base + inc;
    fwd_pos = (fwd_sum >= LEN_W) ? (fwd_sum - LEN_W) : fwd_sum;
    rev_pos = (base >= inc) ? (base - inc) : (base + LEN_W - inc);

    if (!step_i) begin
      pos_nxt_o = base[IDX_W-1:0];
    end else if (dir_i == DIR_FWD) begin
      pos_nxt_o = fwd_pos[IDX_W-1:0];
    end else begin
      pos_nxt_o = rev_pos[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq #(
  parameter int NUM_PHASES = 4,
  localparam int LEN   = 2 * NUM_PHASES,
  localparam int IDX_W = $clog2(LEN),
  localparam int OUT_W = 2 * NUM_PHASES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             dir_i,
  input  logic             half_i,
  output logic [OUT_W-1:0] phase_o
);

  localparam logic [OUT_W-1:0] RST_PATTERN = {2{{(NUM_PHASES-1){1'b0}}, 1'b1}};

  logic             rst_meta_n;
  logic             rst_sync_n;
  logic [IDX_W-1:0] pos_q;
  logic [IDX_W-1:0] pos_nxt;
  logic [OUT_W-1:0] pattern_nxt;
  logic [OUT_W-1:0] phase_q;
  logic             upd_en;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  stepper_pos_next #(.NUM_PHASES(NUM_PHASES)) u_next (
    .pos_i     (pos_q),
    .step_i    (step_i),
    .dir_i     (dir_i),
    .half_i    (half_i),
    .pos_nxt_o (pos_nxt)
  );

  stepper_phase_lut #(.NUM_PHASES(NUM_PHASES)) u_lut (
    .idx_i     (pos_nxt),
    .pattern_o (pattern_nxt)
  );

  // Registers update on a step, or in full-step mode so that an even position snaps.
  assign upd_en = step_i | ~half_i;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pos_q   <= '0;
      phase_q <= RST_PATTERN;
    end else if (upd_en) begin
      pos_q   <= pos_nxt;
      phase_q <= pattern_nxt;
    end
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/stepper_phase_seq_chk.sv
module stepper_phase_seq_chk #(
  parameter int NUM_PHASES = 4,
  localparam int OUT_W = 2 * NUM_PHASES
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             step_i,
  input logic             half_i,
  input logic [OUT_W-1:0] phase_o
);

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_i && half_i) |=> $stable(phase_o));

  // R8
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    step_i |=> !$stable(phase_o));

  // R9
  nibble_match_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    phase_o[OUT_W-1:NUM_PHASES] == phase_o[NUM_PHASES-1:0]);

  // R9
  full_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !half_i |=> ($countones(phase_o[NUM_PHASES-1:0]) == 2));

  // R4
  half_coils_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ($countones(phase_o[NUM_PHASES-1:0]) == 1) || ($countones(phase_o[NUM_PHASES-1:0]) == 2));

endmodule

bind stepper_phase_seq stepper_phase_seq_chk #(.NUM_PHASES(NUM_PHASES)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .step_i     (step_i),
  .half_i     (half_i),
  .phase_o    (phase_o)
);

// File: tb/stepper_phase_seq_test.sv
module stepper_phase_seq_test;

  logic       clk;
  logic       rst_n;
  logic       step_i;
  logic       dir_i;
  logic       half_i;
  logic [7:0] phase_o;

  int n_checks;
  int n_fail;

  stepper_phase_seq uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (step_i),
    .dir_i   (dir_i),
    .half_i  (half_i),
    .phase_o (phase_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] exp);
    n_checks++;
    if (phase_o !== exp) begin
      n_fail++;
      $display("FAIL %s: phase_o actual %h expected %h", req, phase_o, exp);
    end
  endtask

  task automatic do_step(input logic fwd);
    @(negedge clk);
    step_i = 1'b1;
    dir_i  = fwd;
    @(posedge clk);
    @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n  = 1'b0;
    step_i = 1'b0;
    dir_i  = 1'b1;
    half_i = 1'b0;
    wait_cyc(3);
    chk("R1 in reset", 8'h11);
    rst_n = 1'b1;
    wait_cyc(4);
    chk("R1 after release", 8'h33);
  endtask

  task automatic t_full_fwd;
    logic [7:0] exp [4] = '{8'h66, 8'hCC, 8'h99, 8'h33};
    for (int i = 0; i < 4; i++) begin
      do_step(1'b1);
      chk("R2 full forward", exp[i]);
    end
  endtask

  task automatic t_full_rev;
    logic [7:0] exp [4] = '{8'h99, 8'hCC, 8'h66, 8'h33};
    for (int i = 0; i < 4; i++) begin
      do_step(1'b0);
      chk("R3 full reverse", exp[i]);
    end
  endtask

  task automatic t_to_half;
    half_i = 1'b1;
    wait_cyc(3);
    chk("R7 mode raise keeps entry", 8'h33);
    do_step(1'b1);
    chk("R7 continue in half", 8'h22);
  endtask

  task automatic t_half_fwd;
    logic [7:0] exp [8] = '{8'h66, 8'h44, 8'hCC, 8'h88, 8'h99, 8'h11, 8'h33, 8'h22};
    for (int i = 0; i < 8; i++) begin
      do_step(1'b1);
      chk("R4 half forward", exp[i]);
    end
  endtask

  task automatic t_half_rev;
    logic [7:0] exp [4] = '{8'h33, 8'h11, 8'h99, 8'h88};
    for (int i = 0; i < 4; i++) begin
      do_step(1'b0);
      chk("R5 half reverse", exp[i]);
    end
  endtask

  task automatic t_snap;
    half_i = 1'b0;
    wait_cyc(1);
    chk("R6 snap 88 to 99", 8'h99);
    do_step(1'b1);
    chk("R2 after snap", 8'h33);
    half_i = 1'b1;
    do_step(1'b0);
    chk("R5 to 11", 8'h11);
    half_i = 1'b0;
    wait_cyc(1);
    chk("R6 snap 11 to 33", 8'h33);
    chk("R9 full entry", (phase_o[3:0] == phase_o[7:4]) ? phase_o : 8'h00);
  endtask

  task automatic t_idle;
    logic [7:0] held;
    do_step(1'b1);
    chk("R2 step before idle", 8'h66);
    held = phase_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 full idle", held);
    end
    half_i = 1'b1;
    do_step(1'b1);
    chk("R4 half from 66", 8'h44);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R8 half idle", 8'h44);
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    t_reset();
    t_full_fwd();
    t_full_rev();
    t_to_half();
    t_half_fwd();
    t_half_rev();
    t_snap();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule